// File: doc/BRIEF.md
# Signal Cadence Timer Controller

This block switches an oscillator output (a call-progress tone or the ringing waveform) on and off in a repeating cadence. The on period and the off period each come from their own programmable 16-bit count, measured in ticks of an 8 kHz sample strobe, so one count step is 125 µs. Waveform synthesis and the analog line drive sit outside the block; it only decides when the signal is active and which line state is reported.

Ringing begins when the line-state command code for ringing is written while the block is enabled. The output is then active for the on count; when that expires the output goes quiet and the reported line state falls back to on-hook transmission for the off count, after which a new on period starts, indefinitely. Each period end sets its own sticky pending flag, cleared by writing one to it; an interrupt line is raised while any pending flag whose enable is set remains. An off count of zero gives continuous output with no quiet gap. Dropping the enable, or writing any other line-state command, halts the cadence at once.

Top module: `cad_ctrl`

## Requirements
- R1: After reset `sig_active` is 0, `line_state` is 3'b000, both `pend` bits are 0 and `irq` is 0.
- R2: A command write (`cmd_we`=1) of code 3'b100 while `en`=1 makes `sig_active` 1 and `line_state` 3'b100 on the next cycle and loads the on count from `on_len`; a repeat of this write while running restarts the on period.
- R3: The timers advance only in cycles where `tick`=1 and no command is written. An on period lasts `on_len` ticks (a value of 0 or 1 lasts one tick); in the cycle after its last tick `sig_active` is 0, `line_state` is 3'b010 and `pend[0]` is 1, and the off count is loaded from `off_len`.
- R4: An off period lasts `off_len` ticks; in the cycle after its last tick `sig_active` is 1, `line_state` is 3'b100, `pend[1]` is 1, and a fresh on period is loaded, so the cadence repeats.
- R5: If `off_len` is 0 when an on period ends, `sig_active` stays 1, `line_state` stays 3'b100, a new on period is loaded at once and `pend[0]` is still set.
- R6: A 1 in bit k of `pend_clr` clears `pend[k]` on the next cycle; a 0 leaves it; an expiry setting the same bit in that cycle wins over the clear.
- R7: `irq` is 1 exactly when some `pend[k]` is 1 with `irq_en[k]`=1 (same cycle); pending bits are set whether or not their enable is set.
- R8: `en`=0 while the cadence runs (and no command is written) stops both timers: next cycle `sig_active` is 0 and `line_state` is 3'b010, and no further pending bit is set by the cadence.
- R9: A command write of any other code stops the cadence and reports that code in `line_state` next cycle; a write of 3'b100 with `en`=0 reports 3'b010 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 8 kHz sample strobe, one cycle wide |
| en | input | 1 | Cadence enable |
| cmd_we | input | 1 | Line-state command write strobe |
| cmd | input | 3 | Line-state command code |
| on_len | input | 16 | On period length in ticks |
| off_len | input | 16 | Off period length in ticks (0 = continuous) |
| irq_en | input | 2 | Interrupt enables: bit 0 on-end, bit 1 off-end |
| pend_clr | input | 2 | Write-one-to-clear strobes for `pend` |
| sig_active | output | 1 | Oscillator output currently active |
| line_state | output | 3 | Reported line state |
| pend | output | 2 | Pending flags: bit 0 on-end, bit 1 off-end |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume `tick` and the command strobe are plain synchronous inputs with no protocol between them, that a command write takes precedence over a tick in the same cycle, and that length values may change at any time but matter only when loaded. The stimulus keeps lengths small (0 to 5) so that many period boundaries, zero-length and continuous cases occur, fires ticks on a random subset of cycles, and mixes rare command writes, enable drops and clear strobes into long random runs around directed cases for start, continuous output, masking, clearing and both ways of stopping.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam logic [2:0] LS_RING = 3'b100;
  localparam logic [2:0] LS_QUIET = 3'b010;
  localparam int unsigned N_EVT = 2;
  localparam int unsigned EV_ON_END = 0;
  localparam int unsigned EV_OFF_END = 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;

  // A period ends on the tick seen while the remaining count is 0 or 1.
  function automatic logic last_step(input logic [31:0] remaining);
    return remaining <= 32'd1;
  endfunction

  // Reported state for a command that does not start the cadence.
  function automatic logic [2:0] halted_code(input logic [2:0] code);
    return (code == LS_RING) ? LS_QUIET : code;
  endfunction
endpackage

// File: rtl/cad_timer.sv
module cad_timer #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             step,
  output logic             expire
);
  import cad_pkg::*;

  logic [LEN_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = last_step(32'(cnt_q));
  assign expire  = step && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stop) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && !at_last) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cad_seq.sv
module cad_seq #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             cmd_we,
  input  logic [2:0]       cmd,
  input  logic [LEN_W-1:0] on_len,
  input  logic [LEN_W-1:0] off_len,
  input  logic             expire,
  output logic             step,
  output logic             stop,
  output logic             load,
  output logic [LEN_W-1:0] load_val,
  output logic             on_end,
  output logic             off_end,
  output logic             sig_active,
  output logic [2:0]       line_state
);
  import cad_pkg::*;

  phase_t     phase_q, phase_d;
  logic [2:0] state_q, state_d;
  logic       running, start, halt_cmd, halt_en, no_gap;

  assign running  = (phase_q != PH_IDLE);
  assign start    = cmd_we && (cmd == LS_RING) && en;
  assign halt_cmd = cmd_we && !start;
  assign halt_en  = !cmd_we && running && !en;
  assign step     = running && en && tick && !cmd_we;
  assign on_end   = expire && (phase_q == PH_ON);
  assign off_end  = expire && (phase_q == PH_OFF);
  assign no_gap   = (off_len == '0);
  assign stop     = halt_cmd || halt_en;
  assign load     = start || on_end || off_end;
  assign load_val = (on_end && !no_gap) ? off_len : on_len;

  always_comb begin
    phase_d = phase_q;
    state_d = state_q;
    if (start) begin
      phase_d = PH_ON;
      state_d = LS_RING;
    end else if (halt_cmd) begin
      phase_d = PH_IDLE;
      state_d = halted_code(cmd);
    end else if (halt_en) begin
      phase_d = PH_IDLE;
      state_d = LS_QUIET;
    end else if (on_end) begin
      if (!no_gap) begin
        phase_d = PH_OFF;
        state_d = LS_QUIET;
      end
    end else if (off_end) begin
      phase_d = PH_ON;
      state_d = LS_RING;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      state_q <= 3'b000;
    end else begin
      phase_q <= phase_d;
      state_q <= state_d;
    end
  end

  assign sig_active = (phase_q == PH_ON);
  assign line_state = state_q;
endmodule

// File: rtl/cad_irq.sv
module cad_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask_en,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
      end else if (set[k]) begin
        pend_q[k] <= 1'b1;
      end else if (clr[k]) begin
        pend_q[k] <= 1'b0;
      end
    end
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & mask_en);
endmodule

// File: rtl/cad_ctrl.sv
module cad_ctrl #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             cmd_we,
  input  logic [2:0]       cmd,
  input  logic [LEN_W-1:0] on_len,
  input  logic [LEN_W-1:0] off_len,
  input  logic [1:0]       irq_en,
  input  logic [1:0]       pend_clr,
  output logic             sig_active,
  output logic [2:0]       line_state,
  output logic [1:0]       pend,
  output logic             irq
);
  import cad_pkg::*;

  logic             t_step, t_stop, t_load, t_expire;
  logic [LEN_W-1:0] t_val;
  logic             evt_on_end, evt_off_end;
  logic [N_EVT-1:0] evt_set;

  cad_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .en         (en),
    .cmd_we     (cmd_we),
    .cmd        (cmd),
    .on_len     (on_len),
    .off_len    (off_len),
    .expire     (t_expire),
    .step       (t_step),
    .stop       (t_stop),
    .load       (t_load),
    .load_val   (t_val),
    .on_end     (evt_on_end),
    .off_end    (evt_off_end),
    .sig_active (sig_active),
    .line_state (line_state)
  );

  cad_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (t_stop),
    .load     (t_load),
    .load_val (t_val),
    .step     (t_step),
    .expire   (t_expire)
  );

  assign evt_set[EV_ON_END]  = evt_on_end;
  assign evt_set[EV_OFF_END] = evt_off_end;

  cad_irq #(.N(N_EVT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (evt_set),
    .clr     (pend_clr),
    .mask_en (irq_en),
    .pend    (pend),
    .irq     (irq)
  );
endmodule

// File: rtl/cad_ctrl_chk.sv
module cad_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cmd_we,
  input logic [2:0] cmd,
  input logic [1:0] pend_clr,
  input logic [1:0] irq_en,
  input logic       sig_active,
  input logic [2:0] line_state,
  input logic [1:0] pend,
  input logic       irq,
  input logic       evt_on_end,
  input logic       evt_off_end
);
  // R2
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == 3'b100 && en) |=> (sig_active && line_state == 3'b100));
  // R3
  a_r3_on_end_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_on_end |=> pend[0]);
  // R4
  a_r4_off_end_resume: assert property (@(posedge clk) disable iff (!rst_n)
    evt_off_end |=> (sig_active && pend[1] && line_state == 3'b100));
  // R6
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr[0] && !evt_on_end) |=> !pend[0]);
  // R7
  a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & irq_en)) |-> irq);
  // R8
  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sig_active);
  // R9
  a_r9_active_reports_ring: assert property (@(posedge clk) disable iff (!rst_n)
    sig_active |-> line_state == 3'b100);
  // R3
  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_on_end, evt_off_end}));
endmodule

bind cad_ctrl cad_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .cmd_we      (cmd_we),
  .cmd         (cmd),
  .pend_clr    (pend_clr),
  .irq_en      (irq_en),
  .sig_active  (sig_active),
  .line_state  (line_state),
  .pend        (pend),
  .irq         (irq),
  .evt_on_end  (evt_on_end),
  .evt_off_end (evt_off_end)
);

// File: tb/cad_ctrl_tb.sv
module cad_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             en = 1'b0;
  logic             cmd_we = 1'b0;
  logic [2:0]       cmd = 3'b000;
  logic [LEN_W-1:0] on_len = '0;
  logic [LEN_W-1:0] off_len = '0;
  logic [1:0]       irq_en = 2'b00;
  logic [1:0]       pend_clr = 2'b00;
  logic             sig_active;
  logic [2:0]       line_state;
  logic [1:0]       pend;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference state
  logic             m_run = 1'b0;
  logic             m_on = 1'b0;
  logic [LEN_W-1:0] m_cnt = '0;
  logic [2:0]       m_state = 3'b000;
  logic [1:0]       m_pend = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  cad_ctrl #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .cmd_we(cmd_we),
    .cmd(cmd), .on_len(on_len), .off_len(off_len), .irq_en(irq_en),
    .pend_clr(pend_clr), .sig_active(sig_active), .line_state(line_state),
    .pend(pend), .irq(irq)
  );

  function automatic logic exp_irq(input logic [1:0] p, input logic [1:0] m);
    return (p[0] && m[0]) || (p[1] && m[1]);
  endfunction

  task automatic check(input string t, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [1:0] s;
    s = 2'b00;
    if (cmd_we) begin
      if (cmd == 3'b100 && en) begin
        m_run = 1'b1; m_on = 1'b1; m_cnt = on_len; m_state = 3'b100;
      end else begin
        m_run = 1'b0; m_on = 1'b0; m_cnt = '0;
        m_state = (cmd == 3'b100) ? 3'b010 : cmd;
      end
    end else if (m_run && !en) begin
      m_run = 1'b0; m_on = 1'b0; m_cnt = '0; m_state = 3'b010;
    end else if (m_run && tick) begin
      if (m_cnt <= 1) begin
        if (m_on) begin
          s[0] = 1'b1;
          if (off_len == 0) m_cnt = on_len;
          else begin m_on = 1'b0; m_cnt = off_len; m_state = 3'b010; end
        end else begin
          s[1] = 1'b1; m_on = 1'b1; m_cnt = on_len; m_state = 3'b100;
        end
      end else begin
        m_cnt = m_cnt - 1'b1;
      end
    end
    m_pend = (m_pend & ~pend_clr) | s;
  endtask

  task automatic compare();
    check(tag, "sig_active", int'(sig_active), int'(m_on));
    check(tag, "line_state", int'(line_state), int'(m_state));
    check(tag, "pend", int'(pend), int'(m_pend));
    check(tag, "irq", int'(irq), int'(exp_irq(m_pend, irq_en)));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    cmd_we = 1'b0;
    pend_clr = 2'b00;
  endtask

  task automatic run(input int n, input bit all_ticks);
    for (int i = 0; i < n; i++) begin
      tick = all_ticks ? 1'b1 : 1'($urandom_range(0, 1));
      cycle();
    end
  endtask

  task automatic write_cmd(input logic [2:0] c);
    cmd = c; cmd_we = 1'b1; tick = 1'b1;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    check("R1", "sig_active", int'(sig_active), 0);
    check("R1", "line_state", int'(line_state), 0);
    check("R1", "pend", int'(pend), 0);
    check("R1", "irq", int'(irq), 0);

    // R2 / R3 / R4: basic cadence, on=3 off=2, ticks every cycle
    tag = "R2";
    en = 1'b1; on_len = 16'd3; off_len = 16'd2; irq_en = 2'b11;
    write_cmd(3'b100);
    tag = "R3";
    run(4, 1'b1);
    tag = "R4";
    run(8, 1'b1);
    // R3: sparse ticks, zero length
    tag = "R3";
    on_len = 16'd0; off_len = 16'd1;
    write_cmd(3'b100);
    run(20, 1'b0);

    // R6: clears, and set-versus-clear collision
    tag = "R6";
    pend_clr = 2'b11; tick = 1'b0; cycle();
    on_len = 16'd2; off_len = 16'd2;
    write_cmd(3'b100);
    for (int i = 0; i < 12; i++) begin
      tick = 1'b1; pend_clr = 2'b11; cycle();
    end

    // R5: continuous output
    tag = "R5";
    off_len = 16'd0; on_len = 16'd2;
    write_cmd(3'b100);
    run(12, 1'b1);

    // R7: masked pending still sets
    tag = "R7";
    irq_en = 2'b00; off_len = 16'd1; pend_clr = 2'b11; tick = 1'b0; cycle();
    run(10, 1'b1);
    irq_en = 2'b10; run(2, 1'b0);
    irq_en = 2'b01; run(2, 1'b0);

    // R8: enable drop halts the cadence
    tag = "R8";
    pend_clr = 2'b11; tick = 1'b0; cycle();
    en = 1'b0; run(10, 1'b1);
    en = 1'b1; run(5, 1'b1);

    // R9: other command halts; ring with enable low does not start
    tag = "R9";
    write_cmd(3'b100);
    run(2, 1'b1);
    write_cmd(3'b001);
    run(6, 1'b1);
    en = 1'b0;
    write_cmd(3'b100);
    en = 1'b1;
    run(6, 1'b1);
    write_cmd(3'b100);
    run(3, 1'b1);
    write_cmd(3'b100); // R2 restart while running
    run(3, 1'b1);

    // random run
    tag = "R4";
    for (int i = 0; i < 6000; i++) begin
      tick = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 39) == 0) begin
        cmd_we = 1'b1;
        cmd = ($urandom_range(0, 1) == 0) ? 3'b100 : 3'($urandom_range(0, 7));
      end
      en = ($urandom_range(0, 49) != 0);
      pend_clr = {1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0)};
      if ($urandom_range(0, 15) == 0) on_len = 16'($urandom_range(0, 5));
      if ($urandom_range(0, 15) == 0) off_len = 16'($urandom_range(0, 5));
      if ($urandom_range(0, 31) == 0) irq_en = 2'($urandom_range(0, 3));
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule